// File: doc/BRIEF.md
# Two-Wire Serial Bus Byte Master

This block is the only master on an open-drain two-wire serial bus (clock line and data line). It produces the bus clock from the system clock at a programmable period, so one design covers both the 100 kb/s and 400 kb/s bus rates. A host steers it one bus operation at a time: begin a transfer, write a byte, read a byte with a chosen reply, or end the transfer. Each accepted operation ends with a one-cycle completion pulse. The block also reports whether the bus is held, the last byte read, and whether the last written byte was acknowledged.

Each bus line is modelled as a pull-low enable output and a sampled input. The block never drives a line high; it only pulls a line low or lets go of it. The clock input is read back so that a slave holding the clock low can slow the master down. A new transfer can be begun again in the middle of an open one without handing the bus back.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, and after a stop has completed, both pull-low enables are 0 and busy_o is 0.
- R2: Command code 1 (start) is accepted while the bus is free. SDA is pulled low while SCL is released, then SCL is pulled low, and busy_o becomes 1.
- R3: Command code 2 (write) shifts wr_data_i out most significant bit first over eight clocks, where pull-low = inverted bit. A ninth clock follows with SDA released. ack_o is then 1 if SDA read low and 0 if it read high.
- R4: Command code 3 (read) releases SDA for eight clocks and captures the bits most significant first into rd_data_o. On the ninth clock the master pulls SDA low when rd_nack_i was 0 and leaves it released when rd_nack_i was 1.
- R5: Inside a byte, the master changes its SDA enable only while SCL is low, and exactly div/4 (integer) system clocks after SCL falls. No start or stop appears inside a byte.
- R6: Each SCL low phase driven by the master lasts div/2 system clocks. The high phase is timed only from when SCL is read high, so it lasts at least div/2 clocks even when a slave holds SCL low for longer, and at most div/2+3 clocks.
- R7: A start issued while the bus is held makes a repeated start: SDA is released while SCL is low, then pulled low while SCL is high, with no stop and busy_o staying 1.
- R8: Command code 4 (stop) releases SDA while SCL is high, and busy_o returns to 0 when the stop completes.
- R9: A command presented while an earlier one is still running has no effect. Write, read and stop presented while the bus is free are also ignored.
- R10: Every accepted command produces exactly one done_o pulse, one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | 16 | SCL period in system clocks (at least 8), latched when a command is accepted |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code: 1 start, 2 write, 3 read, 4 stop |
| wr_data_i | input | 8 | Byte to write |
| rd_nack_i | input | 1 | For read: 1 leaves the reply bit released (last byte), 0 acknowledges |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Bus held between start and stop |
| ack_o | output | 1 | Acknowledge seen after the last write |
| rd_data_o | output | 8 | Last byte read |

## Verification
The hardest state to reach from the ports is a slave holding SCL low longer than the master's own low phase. In that state, a master that times its high phase from its own release rather than from the line gives a short pulse. The bench's slave model can hold SCL low for a set number of cycles after every falling edge. The bench then measures every high phase of the byte against div/2. A second awkward case is a command strobed in the middle of a running byte. The bench strobes a different write a few cycles after the first one is accepted. It then checks that only the first byte reached the slave and that only one completion pulse came out.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_START = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_READ  = 3'd3,
    CMD_STOP  = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,   // SCL low, SDA placed at quarter
    PH_WAIT,  // SCL released, waiting for line to read high
    PH_HIGH,  // SCL high, timed
    PH_TAIL   // start/stop hold time
  } phase_e;
endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RST_VAL;
        else         r_q <= d_i;
      end
      assign q_o = r_q;
    end else begin : g_chain
      localparam int TOT = STAGES * W;
      logic [TOT-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[TOT-W-1:0], d_i};
      end
      assign q_o = chain_q[TOT-1 -: W];
    end
  endgenerate
endmodule

// File: rtl/i2c_bm_shreg.sv
module i2c_bm_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         msb_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (load_i)  data_q <= load_val_i;
    else if (shift_i) data_q <= {data_q[W-2:0], bit_i};
  end

  assign data_o = data_q;
  assign msb_o  = data_q[W-1];
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  div_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_nack_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int              BIT_W    = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W);

  phase_e             ph_q;
  cmd_e               op_q;
  logic [CNT_W-1:0]   cnt_q, div_q;
  logic [BIT_W-1:0]   bit_q;
  logic               scl_drv_q, sda_drv_q, bus_busy_q, done_q, ack_q, nack_q;
  logic [DATA_W-1:0]  rd_q;

  logic [1:0]         line_s;
  logic               scl_s, sda_s;
  logic [CNT_W-1:0]   half_m1, qtr_m1;
  logic               hit_half, hit_qtr, is_byte, accept;
  logic               sh_load, sh_shift, sh_msb;
  logic [DATA_W-1:0]  sh_data;

  i2c_bm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  assign half_m1  = (div_q >> 1) - 1'b1;
  assign qtr_m1   = (div_q >> 2) - 1'b1;
  assign hit_half = (cnt_q == half_m1);
  assign hit_qtr  = (cnt_q == qtr_m1);
  assign is_byte  = (op_q == CMD_WRITE) || (op_q == CMD_READ);

  // start always accepted on a free engine; others need a held bus
  assign accept = cmd_valid_i && (ph_q == PH_IDLE) &&
                  ((cmd_i == CMD_START) ||
                   (bus_busy_q && ((cmd_i == CMD_WRITE) || (cmd_i == CMD_READ) ||
                                   (cmd_i == CMD_STOP))));

  assign sh_load  = accept && (cmd_i == CMD_WRITE);
  assign sh_shift = (ph_q == PH_HIGH) && hit_half && is_byte && (bit_q != LAST_BIT);

  i2c_bm_shreg #(.W(DATA_W)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .load_val_i(wr_data_i),
    .shift_i   (sh_shift),
    .bit_i     (sda_s),
    .data_o    (sh_data),
    .msb_o     (sh_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      op_q       <= CMD_NONE;
      cnt_q      <= '0;
      div_q      <= CNT_W'(8);
      bit_q      <= '0;
      scl_drv_q  <= 1'b0;
      sda_drv_q  <= 1'b0;
      bus_busy_q <= 1'b0;
      done_q     <= 1'b0;
      ack_q      <= 1'b0;
      nack_q     <= 1'b0;
      rd_q       <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            op_q   <= cmd_e'(cmd_i);
            nack_q <= rd_nack_i;
            div_q  <= div_i;
            cnt_q  <= '0;
            bit_q  <= '0;
            ph_q   <= PH_LOW;
            if (cmd_i == CMD_START) bus_busy_q <= 1'b1;
          end
        end
        PH_LOW: begin
          cnt_q <= cnt_q + 1'b1;
          if (hit_qtr) begin
            unique case (op_q)
              CMD_START: sda_drv_q <= 1'b0;
              CMD_STOP:  sda_drv_q <= 1'b1;
              CMD_WRITE: sda_drv_q <= (bit_q != LAST_BIT) ? ~sh_msb : 1'b0;
              CMD_READ:  sda_drv_q <= (bit_q == LAST_BIT) ? ~nack_q : 1'b0;
              default:   sda_drv_q <= sda_drv_q;
            endcase
          end
          if (hit_half) begin
            scl_drv_q <= 1'b0;
            ph_q      <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          // slave may still hold SCL low
          if (scl_s) begin
            cnt_q <= '0;
            ph_q  <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          cnt_q <= cnt_q + 1'b1;
          if (hit_half) begin
            cnt_q <= '0;
            if (op_q == CMD_START) begin
              sda_drv_q <= 1'b1;
              ph_q      <= PH_TAIL;
            end else if (op_q == CMD_STOP) begin
              sda_drv_q <= 1'b0;
              ph_q      <= PH_TAIL;
            end else begin
              scl_drv_q <= 1'b1;
              if (bit_q == LAST_BIT) begin
                ph_q   <= PH_IDLE;
                done_q <= 1'b1;
                if (op_q == CMD_WRITE) ack_q <= ~sda_s;
                if (op_q == CMD_READ)  rd_q  <= sh_data;
              end else begin
                bit_q <= bit_q + 1'b1;
                ph_q  <= PH_LOW;
              end
            end
          end
        end
        PH_TAIL: begin
          cnt_q <= cnt_q + 1'b1;
          if (hit_half) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
            if (op_q == CMD_START) scl_drv_q  <= 1'b1;
            if (op_q == CMD_STOP)  bus_busy_q <= 1'b0;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_oe_o  = scl_drv_q;
  assign sda_oe_o  = sda_drv_q;
  assign done_o    = done_q;
  assign busy_o    = bus_busy_q;
  assign ack_o     = ack_q;
  assign rd_data_o = rd_q;

  assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  assert_start_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && !scl_oe_o) |-> (op_q == CMD_START));

  assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_HIGH) && is_byte) |-> $stable(sda_oe_o));

  assert_wait_for_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> $past(scl_s));

  assert_stop_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_oe_o) && !scl_oe_o) |-> (op_q == CMD_STOP));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div = 16'd40;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_nack = 1'b0;
  logic        scl_oe, sda_oe, done, busy, ack;
  logic [7:0]  rd_data;

  // slave model state
  int          idx = -1;
  int          hold = 0;
  int          stretch_n = 0;
  bit          slv_mode = 1'b0;   // 0 receive, 1 transmit
  bit          slv_ack_en = 1'b1;
  logic [7:0]  slv_tx = 8'h00;
  logic [7:0]  slv_rx = 8'h00;
  bit          m_ack = 1'b0;
  int          start_cnt = 0, stop_cnt = 0;
  logic        slv_scl_low, slv_sda_low, bus_scl, bus_sda;

  // measurement
  bit          armed = 1'b0;
  int          lo_cnt = 0, hi_cnt = 0;
  int          low_min, low_max, hi_min, hi_max, qd_min, qd_max;
  logic        scl_p = 1'b1, sda_p = 1'b1, oe_p = 1'b0;
  int          done_cnt = 0, done_run = 0, done_run_max = 0;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign slv_scl_low = (hold > 0);
  assign slv_sda_low = (!slv_mode && idx == 8 && slv_ack_en) ||
                       (slv_mode && idx >= 0 && idx < 8 && !slv_tx[7 - idx]);
  assign bus_scl = ~(scl_oe | slv_scl_low);
  assign bus_sda = ~(sda_oe | slv_sda_low);

  i2c_byte_master uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wr_data_i(wr_data), .rd_nack_i(rd_nack), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done), .busy_o(busy),
    .ack_o(ack), .rd_data_o(rd_data)
  );

  always @(posedge clk) begin
    if (done) begin done_cnt++; done_run++; end
    else done_run = 0;
    if (done_run > done_run_max) done_run_max = done_run;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold > 0) hold--;
      if (scl_p && bus_scl && sda_p && !bus_sda) begin start_cnt++; idx = -1; end
      if (scl_p && bus_scl && !sda_p && bus_sda) stop_cnt++;
      if (!scl_p && bus_scl) begin
        if (armed) begin
          if (lo_cnt < low_min) low_min = lo_cnt;
          if (lo_cnt > low_max) low_max = lo_cnt;
        end
        armed = 1'b1;
        hi_cnt = 0;
        if (idx >= 0 && idx < 8) slv_rx = {slv_rx[6:0], bus_sda};
        if (idx == 8) m_ack = !bus_sda;
      end
      if (scl_p && !bus_scl) begin
        if (armed) begin
          if (hi_cnt < hi_min) hi_min = hi_cnt;
          if (hi_cnt > hi_max) hi_max = hi_cnt;
        end
        lo_cnt = 0;
        idx = (idx == 8) ? 0 : idx + 1;
        hold = stretch_n;
      end
      if (bus_scl) hi_cnt++; else lo_cnt++;
      if (armed && sda_oe != oe_p && !bus_scl && !scl_p) begin
        if (lo_cnt - 1 < qd_min) qd_min = lo_cnt - 1;
        if (lo_cnt - 1 > qd_max) qd_max = lo_cnt - 1;
      end
      scl_p = bus_scl; sda_p = bus_sda; oe_p = sda_oe;
    end
  end

  function automatic int exp_half(input int d); return d / 2; endfunction
  function automatic int exp_qtr(input int d);  return d / 4; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic arm();
    armed = 1'b0;
    low_min = 1000000; low_max = 0;
    hi_min = 1000000;  hi_max = 0;
    qd_min = 1000000;  qd_max = -1;
  endtask

  task automatic strobe(input logic [2:0] c, input logic [7:0] d, input logic nk,
                        input logic [15:0] dv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wr_data = d; rd_nack = nk; div = dv;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [7:0] d, input logic nk,
                        input logic [15:0] dv);
    int base;
    base = done_cnt;
    strobe(c, d, nk, dv);
    for (int i = 0; i < 20000 && done_cnt == base; i++) @(negedge clk);
    @(negedge clk);
    #1;
    chk(done_cnt == base + 1, "R10 one done per command", done_cnt - base, 1);
  endtask

  task automatic check_timing(input int dv, input string tag);
    chk(low_min == exp_half(dv) && low_max == exp_half(dv), {tag, " R6 low phase"},
        low_min, exp_half(dv));
    chk(hi_min >= exp_half(dv) && hi_max <= exp_half(dv) + 3, {tag, " R6 high phase"},
        hi_min, exp_half(dv));
    chk(qd_min == exp_qtr(dv) && qd_max == exp_qtr(dv), {tag, " R5 sda quarter"},
        qd_min, exp_qtr(dv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base, sc, pc;
    logic [15:0] dvs [4];
    void'($urandom(32'd20240611));
    dvs[0] = 16'd16; dvs[1] = 16'd24; dvs[2] = 16'd40; dvs[3] = 16'd125;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset state",
        {scl_oe, sda_oe, busy, done}, 0);

    // R9 write while bus free is ignored
    base = done_cnt;
    strobe(3'd2, 8'hFF, 1'b0, 16'd40);
    repeat (200) @(negedge clk); #1;
    chk(done_cnt == base && bus_scl && bus_sda && !busy, "R9 write ignored when free",
        done_cnt - base, 0);

    // R2 start
    do_cmd(3'd1, 8'h00, 1'b0, 16'd40);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(start_cnt == 1 && !bus_scl && !bus_sda, "R2 start on bus", start_cnt, 1);

    // R3 write with ack
    slv_ack_en = 1'b1; arm();
    do_cmd(3'd2, 8'hA5, 1'b0, 16'd40);
    chk(slv_rx == 8'hA5, "R3 write data msb first", slv_rx, 8'hA5);
    chk(ack == 1'b1, "R3 ack seen", ack, 1);
    check_timing(40, "write A5");
    chk(start_cnt == 1 && stop_cnt == 0, "R5 no start/stop inside byte", start_cnt, 1);

    // R3 write with nack
    slv_ack_en = 1'b0; arm();
    do_cmd(3'd2, 8'h3C, 1'b0, 16'd40);
    chk(slv_rx == 8'h3C, "R3 write data 3C", slv_rx, 8'h3C);
    chk(ack == 1'b0, "R3 nack seen", ack, 0);
    slv_ack_en = 1'b1;

    // R4 read with ack then nack
    slv_mode = 1'b1; slv_tx = 8'h96;
    do_cmd(3'd3, 8'h00, 1'b0, 16'd40);
    slv_mode = 1'b0;
    chk(rd_data == 8'h96, "R4 read data 96", rd_data, 8'h96);
    chk(m_ack == 1'b1, "R4 master ack", m_ack, 1);
    slv_mode = 1'b1; slv_tx = 8'h5A;
    do_cmd(3'd3, 8'h00, 1'b1, 16'd40);
    slv_mode = 1'b0;
    chk(rd_data == 8'h5A, "R4 read data 5A", rd_data, 8'h5A);
    chk(m_ack == 1'b0, "R4 master nack on last byte", m_ack, 0);

    // R9 command during running byte ignored
    base = done_cnt;
    strobe(3'd2, 8'h81, 1'b0, 16'd40);
    repeat (5) @(negedge clk);
    strobe(3'd2, 8'h7E, 1'b0, 16'd40);
    for (int i = 0; i < 20000 && done_cnt == base; i++) @(negedge clk);
    repeat (400) @(negedge clk); #1;
    chk(done_cnt == base + 1, "R9 mid-byte command ignored (done count)",
        done_cnt - base, 1);
    chk(slv_rx == 8'h81, "R9 mid-byte command ignored (data)", slv_rx, 8'h81);

    // R7 repeated start
    sc = start_cnt; pc = stop_cnt;
    do_cmd(3'd1, 8'h00, 1'b0, 16'd40);
    chk(start_cnt == sc + 1 && stop_cnt == pc, "R7 repeated start no stop",
        start_cnt - sc, 1);
    chk(busy == 1'b1, "R7 bus stays busy", busy, 1);

    // R6 clock stretching
    stretch_n = 60; arm();
    do_cmd(3'd2, 8'hC3, 1'b0, 16'd40);
    stretch_n = 0;
    chk(slv_rx == 8'hC3, "R6 data under stretch", slv_rx, 8'hC3);
    chk(hi_min >= exp_half(40), "R6 high phase after stretch", hi_min, exp_half(40));
    chk(low_min >= 60, "R6 master waited for release", low_min, 60);

    // R8 stop
    pc = stop_cnt;
    do_cmd(3'd4, 8'h00, 1'b0, 16'd40);
    chk(stop_cnt == pc + 1, "R8 stop on bus", stop_cnt - pc, 1);
    chk(!busy && bus_scl && bus_sda && !scl_oe && !sda_oe, "R8 R1 released after stop",
        busy, 0);
    chk(done_run_max == 1, "R10 done one cycle wide", done_run_max, 1);

    // R9 stop while free ignored
    base = done_cnt;
    strobe(3'd4, 8'h00, 1'b0, 16'd40);
    repeat (100) @(negedge clk); #1;
    chk(done_cnt == base, "R9 stop ignored when free", done_cnt - base, 0);

    // random transactions
    for (int it = 0; it < 8; it++) begin
      logic [15:0] dv;
      int nb;
      dv = dvs[$urandom % 4];
      do_cmd(3'd1, 8'h00, 1'b0, dv);
      chk(busy, "R2 random start busy", busy, 1);
      nb = 1 + ($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        logic [7:0] d;
        bit nk;
        d = 8'($urandom);
        if ($urandom % 2 == 0) begin
          slv_ack_en = bit'($urandom % 2); arm();
          do_cmd(3'd2, d, 1'b0, dv);
          chk(slv_rx == d, "R3 random write data", slv_rx, d);
          chk(ack == slv_ack_en, "R3 random ack", ack, slv_ack_en);
          check_timing(dv, "random write");
        end else begin
          nk = bit'($urandom % 2);
          slv_mode = 1'b1; slv_tx = d;
          do_cmd(3'd3, 8'h00, nk, dv);
          slv_mode = 1'b0;
          chk(rd_data == d, "R4 random read data", rd_data, d);
          chk(m_ack == !nk, "R4 random reply bit", m_ack, !nk);
        end
      end
      slv_ack_en = 1'b1;
      do_cmd(3'd4, 8'h00, 1'b0, dv);
      chk(!busy && bus_scl && bus_sda, "R8 random stop releases", busy, 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule